// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block is the transmit half of a synchronous serial controller. Software loads a data word into a one-word holding stage. When the configured start condition is met, the word moves into a shift register and leaves on a single data line, one bit per bit-clock period. An optional synchronization field, up to 16 bits long, goes out ahead of every payload word. Between frames the line rests at a programmable level.

The bit clock is taken from one of two sources: an internal divider of the system clock, or an external clock input that is synchronized into the system clock domain. It can be inverted, and it is presented on an output pin with an enable that is asserted only when the clock is generated internally. A receiver samples the data line on rising edges of that pin, and the data changes one system cycle after each rising edge. Two status outputs pace software. One shows that the holding stage can take a new word. The other shows that the holding stage is empty and no frame is on the line.

Top module: `sync_frame_tx`

## Requirements
- R1: With `start_mode` = 0 (or 3), a frame starts at the first bit-clock tick once a word is held. With `start_mode` = 1 the frame waits for a rising edge of `fs_in`, and with 2 it waits for a falling edge. Only an edge that arrives while no frame is on the line counts. It stays pending until a word is held.
- R2: Each frame sends `sync_len` bits of `sync_data`, then `data_len_m1`+1 bits of the word. `sync_len` = 0 drops the field, and values above 16 act as 16.
- R3: With `msb_first` = 1 each field starts at its highest used bit. With 0 it starts at bit 0. Each bit stays on `tx_data` for one full bit-clock period and changes only in the cycle after a rising edge of `tx_clk_out`.
- R4: `tx_ready` rises in the cycle the held word is copied into the shift register, which is also the cycle the frame begins.
- R5: A write (`wr_en` high at a clock edge) makes both `tx_ready` and `tx_empty` low in the following cycle.
- R6: `tx_empty` is high only when no word is held and no frame is on the line. Once the last bit has gone, `tx_valid` is low and `tx_data` equals `idle_level`.
- R7: With `clk_src_ext` = 0, `tx_clk_out` toggles every `div_val` system cycles (0 acts as 1) and `tx_clk_oe` is high. With 1, `tx_clk_out` follows `ext_clk` two cycles late and `tx_clk_oe` is low.
- R8: `clk_inv` = 1 inverts the selected clock before it reaches `tx_clk_out` and the shift logic, so bits advance on the opposite edge of the source.
- R9: In start mode 0, a word held when a frame ends follows at once with its own sync field and no idle bit in between. In edge modes each frame needs its own edge.
- R10: After reset `tx_ready` = 1, `tx_empty` = 1, `tx_valid` = 0 and `tx_data` = `idle_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | DATA_W | Word to hold |
| data_len_m1 | input | LEN_W | Payload length minus one |
| sync_len | input | SLEN_W | Sync field length, 0 to SYNC_W |
| sync_data | input | SYNC_W | Sync field contents |
| msb_first | input | 1 | 1: highest bit first, 0: bit 0 first |
| start_mode | input | 2 | 0 continuous, 1 rising edge, 2 falling edge |
| idle_level | input | 1 | Line level between frames |
| clk_src_ext | input | 1 | 1 selects `ext_clk` as bit clock |
| clk_inv | input | 1 | Invert the selected bit clock |
| div_val | input | DIV_W | Half-period of the internal clock in system cycles |
| ext_clk | input | 1 | External bit clock |
| fs_in | input | 1 | External frame-sync input |
| tx_data | output | 1 | Serial data line |
| tx_valid | output | 1 | High while a sync or payload bit is on the line |
| tx_clk_out | output | 1 | Bit clock after selection and inversion |
| tx_clk_oe | output | 1 | Output enable for the bit-clock pin |
| tx_ready | output | 1 | Holding stage can take a word |
| tx_empty | output | 1 | Holding stage empty and line idle |

## Verification
The hardest case to reach is the hand-off at the end of a frame. There, the decision between chaining the next word, going idle, or waiting for an edge depends on the holding stage being refilled while the last bit is still shifting. The bench polls `tx_ready` and writes a second word in the cycle after the first one is loaded, so a word is always held at the end of the frame. It runs this in continuous and edge modes and counts falls of `tx_valid` to tell a chained frame from a restart. Edge starts are shown by holding a written word back for a long window before driving `fs_in`.

// File: rtl/sft_pkg.sv
// Shared types for the synchronous frame transmitter.
package sft_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } tx_state_e;

    localparam logic [1:0] START_CONT = 2'd0;
    localparam logic [1:0] START_RISE = 2'd1;
    localparam logic [1:0] START_FALL = 2'd2;
endpackage

// File: rtl/sft_clkgen.sv
// Bit-clock generation: internal divider or synchronized external clock,
// optional inversion, and a one-cycle tick on each rising edge of the result.
// Assumes the external clock is much slower than clk.
module sft_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_ext,
    input  logic             inv,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ext_clk,
    output logic             bit_tick,
    output logic             clk_pin,
    output logic             clk_pin_oe
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;
    logic             int_clk_q;
    logic             ext_s1_q, ext_s2_q;
    logic             proc_clk;
    logic             proc_prev_q;

    assign limit = (div_val == '0) ? DIV_W'(1) : div_val;

    // Internal divider: toggle the clock every `limit` cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            int_clk_q <= 1'b0;
        end else if (cnt_q >= limit - DIV_W'(1)) begin
            cnt_q     <= '0;
            int_clk_q <= ~int_clk_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // Two-stage synchronizer for the external clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_s1_q <= 1'b0;
            ext_s2_q <= 1'b0;
        end else begin
            ext_s1_q <= ext_clk;
            ext_s2_q <= ext_s1_q;
        end
    end

    assign proc_clk = (src_ext ? ext_s2_q : int_clk_q) ^ inv;

    // Previous level of the processed clock, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) proc_prev_q <= 1'b0;
        else        proc_prev_q <= proc_clk;
    end

    assign bit_tick   = proc_clk & ~proc_prev_q;
    assign clk_pin    = proc_clk;
    assign clk_pin_oe = ~src_ext;
endmodule

// File: rtl/sft_start_det.sv
// Start-event detection: synchronizes the frame-sync input and keeps one
// pending event of the selected edge polarity, captured only while idle.
module sft_start_det
    import sft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fs_in,
    input  logic [1:0] mode,
    input  logic       idle,
    input  logic       consume,
    output logic       pending
);
    logic fs_s1_q, fs_s2_q, fs_d_q;
    logic edge_hit;

    // Synchronize the frame-sync input and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_s1_q <= 1'b0;
            fs_s2_q <= 1'b0;
            fs_d_q  <= 1'b0;
        end else begin
            fs_s1_q <= fs_in;
            fs_s2_q <= fs_s1_q;
            fs_d_q  <= fs_s2_q;
        end
    end

    always_comb begin
        case (mode)
            START_RISE: edge_hit = fs_s2_q & ~fs_d_q;
            START_FALL: edge_hit = ~fs_s2_q & fs_d_q;
            default:    edge_hit = 1'b0;
        endcase
    end

    // Pending flag: set by an edge while idle, cleared when a frame takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)                pending <= 1'b0;
        else if (consume)          pending <= 1'b0;
        else if (idle && edge_hit) pending <= 1'b1;
    end
endmodule

// File: rtl/sft_shifter.sv
// Holding stage, shift registers and frame sequencing. On a bit tick it
// loads a held word, sends the sync field and then the payload, and chains
// the next word in continuous mode. Assumes configuration is stable during
// a frame.
module sft_shifter
    import sft_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SYNC_W = 16,
    parameter int LEN_W  = 5,
    parameter int SLEN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  data_len_m1,
    input  logic [SLEN_W-1:0] sync_len,
    input  logic [SYNC_W-1:0] sync_data,
    input  logic              msb_first,
    input  logic              cont_mode,
    input  logic              start_pend,
    output logic              out_bit,
    output logic              out_valid,
    output logic              hold_full,
    output logic              idle,
    output logic              consume
);
    localparam int CNT_W = (LEN_W > SLEN_W) ? LEN_W : SLEN_W;

    tx_state_e         st_q;
    logic [DATA_W-1:0] hold_q, word_q, word_ld;
    logic [SYNC_W-1:0] sync_q, sync_ld;
    logic [CNT_W-1:0]  cnt_q;
    logic [SLEN_W-1:0] slen_eff;
    logic              load;

    function automatic logic [DATA_W-1:0] wshift(input logic [DATA_W-1:0] v,
                                                 input logic m);
        return m ? (v << 1) : (v >> 1);
    endfunction

    function automatic logic wpick(input logic [DATA_W-1:0] v, input logic m);
        return m ? v[DATA_W-1] : v[0];
    endfunction

    function automatic logic [SYNC_W-1:0] sshift(input logic [SYNC_W-1:0] v,
                                                 input logic m);
        return m ? (v << 1) : (v >> 1);
    endfunction

    function automatic logic spick(input logic [SYNC_W-1:0] v, input logic m);
        return m ? v[SYNC_W-1] : v[0];
    endfunction

    // Clamp the sync length and align both fields for the chosen bit order.
    always_comb begin
        slen_eff = (int'(sync_len) > SYNC_W) ? SLEN_W'(SYNC_W) : sync_len;
        word_ld  = msb_first ? (hold_q << (DATA_W - 1 - int'(data_len_m1))) : hold_q;
        sync_ld  = msb_first ? (sync_data << (SYNC_W - int'(slen_eff))) : sync_data;
    end

    assign idle    = (st_q == ST_IDLE);
    assign load    = bit_tick && hold_full &&
                     ((idle && (cont_mode || start_pend)) ||
                      (st_q == ST_DATA && cnt_q == '0 && cont_mode));
    assign consume = load && idle;

    // Holding stage: a write fills it, a load into the shifter empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else begin
            if (wr_en) hold_q <= wr_data;
            hold_full <= wr_en | (hold_full & ~load);
        end
    end

    // Frame sequencer: start, sync phase, payload phase, end or chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            word_q    <= '0;
            sync_q    <= '0;
            cnt_q     <= '0;
            out_bit   <= 1'b0;
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            if (slen_eff != '0) begin
                st_q    <= ST_SYNC;
                out_bit <= spick(sync_ld, msb_first);
                sync_q  <= sshift(sync_ld, msb_first);
                word_q  <= word_ld;
                cnt_q   <= CNT_W'(slen_eff - SLEN_W'(1));
            end else begin
                st_q    <= ST_DATA;
                out_bit <= wpick(word_ld, msb_first);
                word_q  <= wshift(word_ld, msb_first);
                cnt_q   <= CNT_W'(data_len_m1);
            end
        end else if (bit_tick) begin
            case (st_q)
                ST_SYNC: begin
                    if (cnt_q == '0) begin
                        st_q    <= ST_DATA;
                        out_bit <= wpick(word_q, msb_first);
                        word_q  <= wshift(word_q, msb_first);
                        cnt_q   <= CNT_W'(data_len_m1);
                    end else begin
                        out_bit <= spick(sync_q, msb_first);
                        sync_q  <= sshift(sync_q, msb_first);
                        cnt_q   <= cnt_q - CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (cnt_q == '0) begin
                        st_q      <= ST_IDLE;
                        out_valid <= 1'b0;
                    end else begin
                        out_bit <= wpick(word_q, msb_first);
                        word_q  <= wshift(word_q, msb_first);
                        cnt_q   <= cnt_q - CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sync_frame_tx.sv
// Top level of the synchronous frame transmitter: ties the bit-clock
// generator, start-event detector and shifter together and forms the
// status flags. All logic runs on clk; the bit clock is an enable.
module sync_frame_tx
    import sft_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SYNC_W = 16,
    parameter int DIV_W  = 8,
    localparam int LEN_W  = $clog2(DATA_W),
    localparam int SLEN_W = $clog2(SYNC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  data_len_m1,
    input  logic [SLEN_W-1:0] sync_len,
    input  logic [SYNC_W-1:0] sync_data,
    input  logic              msb_first,
    input  logic [1:0]        start_mode,
    input  logic              idle_level,
    input  logic              clk_src_ext,
    input  logic              clk_inv,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              ext_clk,
    input  logic              fs_in,
    output logic              tx_data,
    output logic              tx_valid,
    output logic              tx_clk_out,
    output logic              tx_clk_oe,
    output logic              tx_ready,
    output logic              tx_empty
);
    logic bit_tick;
    logic start_pend;
    logic shift_bit;
    logic hold_full;
    logic line_idle;
    logic consume;
    logic cont_mode;

    assign cont_mode = (start_mode != START_RISE) && (start_mode != START_FALL);

    sft_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_ext    (clk_src_ext),
        .inv        (clk_inv),
        .div_val    (div_val),
        .ext_clk    (ext_clk),
        .bit_tick   (bit_tick),
        .clk_pin    (tx_clk_out),
        .clk_pin_oe (tx_clk_oe)
    );

    sft_start_det u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .fs_in   (fs_in),
        .mode    (start_mode),
        .idle    (line_idle),
        .consume (consume),
        .pending (start_pend)
    );

    sft_shifter #(
        .DATA_W (DATA_W),
        .SYNC_W (SYNC_W),
        .LEN_W  (LEN_W),
        .SLEN_W (SLEN_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .data_len_m1 (data_len_m1),
        .sync_len    (sync_len),
        .sync_data   (sync_data),
        .msb_first   (msb_first),
        .cont_mode   (cont_mode),
        .start_pend  (start_pend),
        .out_bit     (shift_bit),
        .out_valid   (tx_valid),
        .hold_full   (hold_full),
        .idle        (line_idle),
        .consume     (consume)
    );

    assign tx_data  = tx_valid ? shift_bit : idle_level;
    assign tx_ready = ~hold_full;
    assign tx_empty = ~hold_full & line_idle;
endmodule

// File: rtl/sft_checker.sv
// Protocol checks for the frame transmitter, bound to the top module.
module sft_checker
    import sft_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] start_mode,
    input logic       bit_tick,
    input logic       start_pend,
    input logic       tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_empty
);
    // R1: a frame begins only on a bit tick
    p_start_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(bit_tick));

    // R1: in edge modes a frame begins only from a pending event
    p_wait_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_valid) && (start_mode == START_RISE || start_mode == START_FALL))
        |-> $past(start_pend));

    // R3: a bit on the line changes only after a tick
    p_bit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_valid) && !$past(bit_tick)) |-> $stable(tx_data));

    // R4: ready returns only when a tick moves the word to the shifter
    p_ready_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> $past(bit_tick));

    // R5: a write clears both flags in the next cycle
    p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!tx_ready && !tx_empty));

    // R6: empty never coincides with a frame on the line
    p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !tx_valid);
endmodule

bind sync_frame_tx sft_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .start_mode (start_mode),
    .bit_tick   (bit_tick),
    .start_pend (start_pend),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_empty   (tx_empty)
);

// File: tb/sync_frame_tx_test.sv
module sync_frame_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int SYNC_W = 16;
    localparam int DIV_W  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  data_len_m1 = '0;
    logic [4:0]  sync_len = '0;
    logic [15:0] sync_data = '0;
    logic        msb_first = 1'b1;
    logic [1:0]  start_mode = 2'd0;
    logic        idle_level = 1'b0;
    logic        clk_src_ext = 1'b0;
    logic        clk_inv = 1'b0;
    logic [7:0]  div_val = 8'd1;
    logic        ext_clk = 1'b0;
    logic        fs_in = 1'b0;
    logic        tx_data, tx_valid, tx_clk_out, tx_clk_oe, tx_ready, tx_empty;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic       ext_run = 1'b0;
    logic       ext_force = 1'b0;
    int         ext_cnt = 0;

    logic       co_prev = 1'b0;
    logic       val_prev = 1'b0;
    logic       cap [0:127];
    int         cap_n = 0;
    int         val_falls = 0;
    logic       exp_b [0:127];
    int         exp_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_frame_tx #(.DATA_W(DATA_W), .SYNC_W(SYNC_W), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .data_len_m1(data_len_m1), .sync_len(sync_len), .sync_data(sync_data),
        .msb_first(msb_first), .start_mode(start_mode), .idle_level(idle_level),
        .clk_src_ext(clk_src_ext), .clk_inv(clk_inv), .div_val(div_val),
        .ext_clk(ext_clk), .fs_in(fs_in), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_clk_out(tx_clk_out), .tx_clk_oe(tx_clk_oe), .tx_ready(tx_ready),
        .tx_empty(tx_empty)
    );

    // External clock source: free-running half-period of 5 cycles, or forced.
    always @(negedge clk) begin
        if (ext_run) begin
            ext_cnt = ext_cnt + 1;
            if (ext_cnt >= 5) begin
                ext_cnt = 0;
                ext_clk = ~ext_clk;
            end
        end else begin
            ext_clk = ext_force;
        end
    end

    // Receiver model: sample the line on each rising edge of the bit clock.
    always @(negedge clk) begin
        if (tx_clk_out && !co_prev && tx_valid && cap_n < 128) begin
            cap[cap_n] = tx_data;
            cap_n = cap_n + 1;
        end
        if (val_prev && !tx_valid) val_falls = val_falls + 1;
        co_prev = tx_clk_out;
        val_prev = tx_valid;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Append the expected bits of one frame to the expected stream.
    task automatic add_expected(input logic [31:0] w, input int len,
                                input logic [15:0] s, input int slen, input bit msb);
        for (int i = 0; i < slen; i++) begin
            exp_b[exp_n] = msb ? s[slen-1-i] : s[i];
            exp_n++;
        end
        for (int i = 0; i < len; i++) begin
            exp_b[exp_n] = msb ? w[len-1-i] : w[i];
            exp_n++;
        end
    endtask

    task automatic wait_empty(input string req);
        int t = 0;
        while (!tx_empty && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(tx_empty == 1'b1, req, "timeout waiting for empty", t, 0);
    endtask

    task automatic compare_stream(input string req);
        int bad = -1;
        check(cap_n == exp_n, req, "captured bit count", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (bad < 0 && cap[i] !== exp_b[i]) bad = i;
        check(bad < 0, req, "first mismatching bit index", bad, -1);
    endtask

    task automatic clear_capture();
        cap_n = 0;
        exp_n = 0;
        val_falls = 0;
    endtask

    // Rise-to-rise distance of tx_clk_out in system cycles.
    task automatic measure_period(output int per);
        logic p;
        int t = 0;
        per = 0;
        p = tx_clk_out;
        while (!(tx_clk_out && !p) && t < 1000) begin p = tx_clk_out; @(negedge clk); t++; end
        p = tx_clk_out;
        @(negedge clk);
        per = 1;
        while (!(tx_clk_out && !p) && per < 1000) begin p = tx_clk_out; @(negedge clk); per++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin
        int per;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R10: reset state
        check(tx_ready == 1'b1, "R10", "ready after reset", tx_ready, 1);
        check(tx_empty == 1'b1, "R10", "empty after reset", tx_empty, 1);
        check(tx_valid == 1'b0, "R10", "valid after reset", tx_valid, 0);
        check(tx_data == idle_level, "R10", "line after reset", tx_data, idle_level);

        // R7: internal divider period and pin enable
        div_val = 8'd3;
        cyc(4);
        measure_period(per);
        check(per == 6, "R7", "internal period for div 3", per, 6);
        check(tx_clk_oe == 1'b1, "R7", "oe with internal clock", tx_clk_oe, 1);
        div_val = 8'd0;
        cyc(4);
        measure_period(per);
        check(per == 2, "R7", "internal period for div 0", per, 2);
        div_val = 8'd1;

        // R7/R8: external source follows ext_clk, inverted when asked
        clk_src_ext = 1'b1;
        ext_force = 1'b1;
        cyc(5);
        check(tx_clk_oe == 1'b0, "R7", "oe with external clock", tx_clk_oe, 0);
        check(tx_clk_out == 1'b1, "R7", "pin follows ext high", tx_clk_out, 1);
        clk_inv = 1'b1;
        cyc(2);
        check(tx_clk_out == 1'b0, "R8", "inverted ext high", tx_clk_out, 0);
        ext_force = 1'b0;
        cyc(5);
        check(tx_clk_out == 1'b1, "R8", "inverted ext low", tx_clk_out, 1);
        clk_inv = 1'b0;
        clk_src_ext = 1'b0;
        cyc(4);

        // R1/R2/R3/R4/R5/R6: continuous sweep over lengths, sync sizes, order
        for (int m = 0; m < 2; m++) begin
            for (int si = 0; si < 4; si++) begin
                for (int len = 1; len <= 32; len++) begin
                    int slen;
                    logic [31:0] w;
                    slen = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 5 : 16;
                    w = $urandom;
                    msb_first = m[0];
                    sync_len = 5'(slen);
                    sync_data = 16'($urandom);
                    data_len_m1 = 5'(len - 1);
                    idle_level = len[0];
                    cyc(2);
                    clear_capture();
                    write_word(w);
                    check(!tx_ready && !tx_empty, "R5", "flags after write",
                          {tx_ready, tx_empty}, 0);
                    add_expected(w, len, sync_data, slen, m[0]);
                    wait_empty("R2");
                    compare_stream(m[0] ? "R3 msb R2" : "R3 lsb R2");
                    check(tx_valid == 1'b0 && tx_data == idle_level, "R6",
                          "line after frame", tx_data, idle_level);
                end
            end
        end

        // R2: sync length above 16 acts as 16
        msb_first = 1'b1;
        sync_len = 5'd20;
        sync_data = 16'hA5C3;
        data_len_m1 = 5'd7;
        clear_capture();
        write_word(32'h0000_005A);
        add_expected(32'h5A, 8, 16'hA5C3, 16, 1'b1);
        wait_empty("R2");
        compare_stream("R2 clamp");

        // R4/R9: continuous back-to-back chaining
        sync_len = 5'd3;
        sync_data = 16'h0005;
        data_len_m1 = 5'd9;
        clear_capture();
        write_word(32'h0000_02D3);
        begin
            int t = 0;
            while (!tx_ready && t < 1000) begin @(negedge clk); t++; end
        end
        check(tx_valid == 1'b1 && tx_empty == 1'b0, "R4", "frame live when ready returns",
              tx_valid, 1);
        write_word(32'h0000_0135);
        add_expected(32'h2D3, 10, 16'h5, 3, 1'b1);
        add_expected(32'h135, 10, 16'h5, 3, 1'b1);
        wait_empty("R9");
        compare_stream("R9 chain");
        check(val_falls == 1, "R9", "valid falls for chained frames", val_falls, 1);

        // R1: rising-edge start waits for fs_in
        start_mode = 2'd1;
        fs_in = 1'b0;
        msb_first = 1'b0;
        cyc(5);
        clear_capture();
        write_word(32'h0000_00C6);
        cyc(60);
        check(tx_valid == 1'b0 && tx_ready == 1'b0, "R1", "rise mode holds word",
              tx_valid, 0);
        fs_in = 1'b1;
        add_expected(32'hC6, 10, 16'h5, 3, 1'b0);
        wait_empty("R1");
        compare_stream("R1 rise");

        // R1: falling-edge start; a rising edge does not start it
        start_mode = 2'd2;
        cyc(5);
        clear_capture();
        write_word(32'h0000_0317);
        cyc(60);
        check(tx_valid == 1'b0, "R1", "fall mode holds word", tx_valid, 0);
        fs_in = 1'b0;
        add_expected(32'h317, 10, 16'h5, 3, 1'b0);
        wait_empty("R1");
        compare_stream("R1 fall");

        // R9: edge mode needs one edge per frame
        start_mode = 2'd1;
        cyc(5);
        clear_capture();
        write_word(32'h0000_0111);
        fs_in = 1'b1;
        begin
            int t = 0;
            while (!tx_ready && t < 1000) begin @(negedge clk); t++; end
        end
        write_word(32'h0000_0222);
        begin
            int t = 0;
            while (tx_valid && t < 1000) begin @(negedge clk); t++; end
        end
        cyc(60);
        check(tx_valid == 1'b0 && tx_empty == 1'b0, "R9", "second frame waits for edge",
              tx_valid, 0);
        fs_in = 1'b0;
        cyc(10);
        fs_in = 1'b1;
        add_expected(32'h111, 10, 16'h5, 3, 1'b0);
        add_expected(32'h222, 10, 16'h5, 3, 1'b0);
        wait_empty("R9");
        compare_stream("R9 edge frames");

        // R7/R8: frame clocked from external clock, inverted
        start_mode = 2'd0;
        clk_src_ext = 1'b1;
        clk_inv = 1'b1;
        ext_run = 1'b1;
        msb_first = 1'b1;
        cyc(20);
        clear_capture();
        write_word(32'h0000_03A9);
        add_expected(32'h3A9, 10, 16'h5, 3, 1'b1);
        wait_empty("R7");
        compare_stream("R7 R8 external frame");

        cyc(5);
        finish_run();
    end
endmodule